// File: doc/BRIEF.md
# Polyphase Scaler Phase Accumulator

This block drives one direction (horizontal or vertical) of a polyphase image scaler. For every output pixel it gives the filter phase (one of 64) and the amount by which the source position moves. It also gives the source pixel indices that the filter taps must fetch. The position is an unsigned fixed-point accumulator with 24 fractional bits. It is loaded at the start of each line and then advanced by the programmed scale ratio on each output-pixel strobe.

The block takes the tap count of its own direction and the tap count of the other direction. When both are single-tap, scaling is off and the block falls back to a one-to-one bypass. Source taps that fall outside the viewport are handled by a selectable policy: either the edge pixel is reused, or the tap is marked to be replaced by the black value. Coefficient lookup and the multiply-accumulate datapath sit downstream and are not part of this block.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, `out_phase` is 0, `out_step` is 0 and all bits of `out_tap_en` are 0, until the first accepted strobe.
- R2: A `line_start` pulse samples `cfg_ratio`, `cfg_init_frac`, `cfg_taps_m1` and `cfg_other_taps_m1` into line-wide copies, and sets the position to integer part 1 with fractional part `cfg_init_frac`. Changes to these four inputs at any other time have no effect on the outputs of the current line.
- R3: `cfg_ratio` is an unsigned value with 2 integer bits and 19 fractional bits. The block uses it shifted left by 5, as a ratio with 24 fractional bits. Each accepted strobe adds that ratio to the position.
- R4: `out_phase` equals the top 6 fractional bits (bits 23..18) of the position that belongs to the output pixel.
- R5: `out_step` equals the integer part of (position + ratio) minus the integer part of the position. Its range is 0 to 4.
- R6: A strobe on `pix_strobe` without `line_start` in the same cycle is accepted. `out_valid` is then 1 in the cycle after that clock edge, with all outputs for that pixel, and 0 in every other cycle. When `line_start` and `pix_strobe` are high together, the line start wins and no output is produced.
- R7: The tap-count field gives the tap count minus one: 0 gives 1 tap, 1 gives 2 taps, 3 gives 4 taps. With N taps and base b = (integer part of position) − 1, tap k (for k < N) targets source index b − (N−1)/2 + k, using integer division. Only the low N bits of `out_tap_en` are set.
- R8: With `cfg_edge_replicate` = 1, a tap index below 0 reports 0 and a tap index at or above `cfg_width` reports `cfg_width`−1. No black flag is set in this mode.
- R9: With `cfg_edge_replicate` = 0, each enabled tap whose index is out of range has its `out_tap_black` bit set, and its index is reported clamped as in R8. In-range taps never carry the flag.
- R10: When (own taps + other taps) ≤ 2, the line runs in bypass and `out_bypass` is 1. The sampled ratio and fractional init are ignored: the phase is 0, the step is 1, one tap is enabled, and the n-th output of the line (counting from 0) targets source index n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ratio | input | 21 | Scale ratio, unsigned 2.19 |
| cfg_init_frac | input | 24 | Fractional part of the initial position |
| cfg_taps_m1 | input | 2 | Tap count minus one for this direction |
| cfg_other_taps_m1 | input | 2 | Tap count minus one for the other direction |
| cfg_width | input | IDX_W | Viewport extent in source pixels (at least 1) |
| cfg_edge_replicate | input | 1 | 1 = reuse edge pixel, 0 = flag black |
| line_start | input | 1 | Start-of-line strobe |
| pix_strobe | input | 1 | Output-pixel strobe |
| out_valid | output | 1 | Outputs below belong to an accepted strobe |
| out_phase | output | 6 | Filter phase index 0..63 |
| out_step | output | 3 | Source pixels to advance after this output |
| out_bypass | output | 1 | Current line runs in bypass |
| out_tap_en | output | MAX_TAPS | Tap enables |
| out_tap_black | output | MAX_TAPS | Tap must be replaced by black |
| out_tap_idx | output | MAX_TAPS×IDX_W | Clamped source index per tap |

## Verification
Every per-pixel result comes from registers that are written on the edge where the strobe is sampled. So phase, step, tap enables, indices and black flags are all due in the cycle after that edge. The bench drives on falling edges and compares on the next falling edge, so it compares exactly one cycle after the strobe. A line-start pulse takes effect on its own edge, and the bench advances its reference position only in the cycle it compares an output. The cycle after each output is also checked to confirm that `out_valid` has dropped, and a cycle with line start and strobe together is checked for the absence of an output.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;

    localparam int FRAC_W      = 24;
    localparam int RAW_FRAC_W  = 19;
    localparam int RAW_INT_W   = 2;
    localparam int RAW_W       = RAW_INT_W + RAW_FRAC_W;
    localparam int RATIO_SHIFT = FRAC_W - RAW_FRAC_W;
    localparam int RATIO_W     = RAW_INT_W + FRAC_W;
    localparam int PHASE_W     = 6;
    localparam int STEP_W      = 3;
    localparam int TAPF_W      = 2;
    localparam int NT_W        = 3;
    localparam int TAPS_MAX    = 4;

    typedef enum logic {
        EDGE_BLACK     = 1'b0,
        EDGE_REPLICATE = 1'b1
    } edge_mode_e;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [FRAC_W-1:0]  init_frac;
        logic [NT_W-1:0]    ntaps;
        logic               bypass;
    } line_cfg_t;

    function automatic logic [NT_W-1:0] taps_from_field(input logic [TAPF_W-1:0] f);
        case (f)
            2'd0:    return NT_W'(1);
            2'd1:    return NT_W'(2);
            default: return NT_W'(4);
        endcase
    endfunction

    function automatic logic scaling_off(input logic [TAPF_W-1:0] own,
                                         input logic [TAPF_W-1:0] other);
        logic [NT_W:0] sum;
        sum = {1'b0, taps_from_field(own)} + {1'b0, taps_from_field(other)};
        return (sum <= (NT_W+1)'(2));
    endfunction

    localparam logic [RATIO_W-1:0] UNITY_RATIO = RATIO_W'(1) << FRAC_W;

endpackage

// File: rtl/scl_line_cfg.sv
module scl_line_cfg
    import scl_phase_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [RAW_W-1:0]     ratio_raw,
    input  logic [FRAC_W-1:0]    init_frac,
    input  logic [TAPF_W-1:0]    taps_f,
    input  logic [TAPF_W-1:0]    other_taps_f,
    output line_cfg_t            cfg_d,
    output line_cfg_t            cfg_q
);

    always_comb begin
        cfg_d.bypass = scaling_off(taps_f, other_taps_f);
        cfg_d.ntaps  = taps_from_field(taps_f);
        if (cfg_d.bypass) begin
            cfg_d.ratio     = UNITY_RATIO;
            cfg_d.init_frac = '0;
        end else begin
            cfg_d.ratio     = {ratio_raw, {RATIO_SHIFT{1'b0}}};
            cfg_d.init_frac = init_frac;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.ratio     <= UNITY_RATIO;
            cfg_q.init_frac <= '0;
            cfg_q.ntaps     <= NT_W'(1);
            cfg_q.bypass    <= 1'b1;
        end else if (load) begin
            cfg_q <= cfg_d;
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/scl_pos_acc.sv
module scl_pos_acc
    import scl_phase_pkg::*;
#(
    parameter int POS_INT_W = 14,
    localparam int POS_W    = POS_INT_W + FRAC_W
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 adv,
    input  logic [FRAC_W-1:0]    load_frac,
    input  logic [RATIO_W-1:0]   ratio,
    output logic [POS_W-1:0]     pos,
    output logic [STEP_W-1:0]    step
);

    logic [POS_W-1:0]     sum;
    logic [POS_INT_W-1:0] int_diff;

    always_comb begin
        sum      = pos + {{(POS_W-RATIO_W){1'b0}}, ratio};
        int_diff = sum[FRAC_W +: POS_INT_W] - pos[FRAC_W +: POS_INT_W];
        step     = int_diff[STEP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= {POS_INT_W'(1), {FRAC_W{1'b0}}};
        end else if (load) begin
            pos <= {POS_INT_W'(1), load_frac};
        end else if (adv) begin
            pos <= sum;
        end
    end

    AST_LOAD_INT_ONE: assert property (@(posedge clk) disable iff (rst)
        load |=> pos[FRAC_W +: POS_INT_W] == POS_INT_W'(1)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load && !adv |=> $stable(pos)); // R3

endmodule

// File: rtl/scl_tap_map.sv
module scl_tap_map
    import scl_phase_pkg::*;
#(
    parameter int IDX_W     = 12,
    parameter int MAX_TAPS  = TAPS_MAX,
    parameter int POS_INT_W = IDX_W + 2
)(
    input  logic [POS_INT_W-1:0]                pos_int,
    input  logic [NT_W-1:0]                     ntaps,
    input  logic [IDX_W-1:0]                    width,
    input  edge_mode_e                          edge_mode,
    output logic [MAX_TAPS-1:0]                 tap_en,
    output logic [MAX_TAPS-1:0]                 tap_black,
    output logic [MAX_TAPS-1:0][IDX_W-1:0]      tap_idx
);

    localparam int SW = POS_INT_W + 2;

    logic signed [SW-1:0] base_s;
    logic signed [SW-1:0] off_s;
    logic signed [SW-1:0] width_s;
    logic [NT_W-1:0]      half_m;

    always_comb begin
        half_m  = (ntaps - NT_W'(1)) >> 1;
        base_s  = $signed({2'b00, pos_int}) - SW'(1);
        off_s   = $signed({{(SW-NT_W){1'b0}}, half_m});
        width_s = $signed({{(SW-IDX_W){1'b0}}, width});
    end

    for (genvar k = 0; k < MAX_TAPS; k++) begin : g_tap
        logic signed [SW-1:0] t_s;
        logic                 en_k;
        logic                 low_k;
        logic                 high_k;
        logic [IDX_W-1:0]     clamp_k;

        always_comb begin
            t_s    = base_s - off_s + SW'(k);
            en_k   = (NT_W'(k) < ntaps);
            low_k  = (t_s < 0);
            high_k = !low_k && (t_s >= width_s);
            if (low_k)       clamp_k = '0;
            else if (high_k) clamp_k = width - IDX_W'(1);
            else             clamp_k = t_s[IDX_W-1:0];
            tap_en[k]    = en_k;
            tap_idx[k]   = en_k ? clamp_k : '0;
            tap_black[k] = en_k && (low_k || high_k) && (edge_mode == EDGE_BLACK);
        end
    end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_phase_pkg::*;
#(
    parameter int IDX_W    = 12,
    parameter int MAX_TAPS = TAPS_MAX
)(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [20:0]                      cfg_ratio,
    input  logic [23:0]                      cfg_init_frac,
    input  logic [1:0]                       cfg_taps_m1,
    input  logic [1:0]                       cfg_other_taps_m1,
    input  logic [IDX_W-1:0]                 cfg_width,
    input  logic                             cfg_edge_replicate,
    input  logic                             line_start,
    input  logic                             pix_strobe,
    output logic                             out_valid,
    output logic [5:0]                       out_phase,
    output logic [2:0]                       out_step,
    output logic                             out_bypass,
    output logic [MAX_TAPS-1:0]              out_tap_en,
    output logic [MAX_TAPS-1:0]              out_tap_black,
    output logic [MAX_TAPS-1:0][IDX_W-1:0]   out_tap_idx
);

    localparam int POS_INT_W = IDX_W + 2;
    localparam int POS_W     = POS_INT_W + FRAC_W;

    line_cfg_t                         cfg_d;
    line_cfg_t                         cfg_q;
    logic                              adv;
    logic [POS_W-1:0]                  pos;
    logic [STEP_W-1:0]                 step;
    logic [MAX_TAPS-1:0]               tap_en;
    logic [MAX_TAPS-1:0]               tap_black;
    logic [MAX_TAPS-1:0][IDX_W-1:0]    tap_idx;
    edge_mode_e                        edge_mode;

    assign adv       = pix_strobe && !line_start;
    assign edge_mode = cfg_edge_replicate ? EDGE_REPLICATE : EDGE_BLACK;

    scl_line_cfg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .load         (line_start),
        .ratio_raw    (cfg_ratio),
        .init_frac    (cfg_init_frac),
        .taps_f       (cfg_taps_m1),
        .other_taps_f (cfg_other_taps_m1),
        .cfg_d        (cfg_d),
        .cfg_q        (cfg_q)
    );

    scl_pos_acc #(.POS_INT_W(POS_INT_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .load      (line_start),
        .adv       (adv),
        .load_frac (cfg_d.init_frac),
        .ratio     (cfg_q.ratio),
        .pos       (pos),
        .step      (step)
    );

    scl_tap_map #(.IDX_W(IDX_W), .MAX_TAPS(MAX_TAPS), .POS_INT_W(POS_INT_W)) u_map (
        .pos_int   (pos[FRAC_W +: POS_INT_W]),
        .ntaps     (cfg_q.ntaps),
        .width     (cfg_width),
        .edge_mode (edge_mode),
        .tap_en    (tap_en),
        .tap_black (tap_black),
        .tap_idx   (tap_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_phase     <= '0;
            out_step      <= '0;
            out_bypass    <= 1'b0;
            out_tap_en    <= '0;
            out_tap_black <= '0;
            out_tap_idx   <= '0;
        end else begin
            out_valid <= adv;
            if (adv) begin
                out_phase     <= pos[FRAC_W-1 -: PHASE_W];
                out_step      <= step;
                out_bypass    <= cfg_q.bypass;
                out_tap_en    <= tap_en;
                out_tap_black <= tap_black;
                out_tap_idx   <= tap_idx;
            end
        end
    end

    AST_VALID_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pix_strobe) && !$past(line_start)); // R6

    AST_START_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !out_valid); // R6

    AST_BYPASS_UNITY: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_bypass |-> out_phase == '0 && out_step == 3'd1); // R10

    AST_TAP_COUNT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(out_tap_en) == 1 || $countones(out_tap_en) == 2
                      || $countones(out_tap_en) == 4); // R7

    AST_BLACK_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
        out_valid && (|out_tap_black) |-> !$past(cfg_edge_replicate)); // R9

    AST_IDX_IN_VIEW: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(cfg_width) != '0 |-> out_tap_idx[0] < $past(cfg_width)); // R8

endmodule

// File: tb/scl_phase_gen_test.sv
module scl_phase_gen_test;

    localparam int IDX_W = 12;
    localparam int NT    = 4;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic [20:0]                  cfg_ratio = '0;
    logic [23:0]                  cfg_init_frac = '0;
    logic [1:0]                   cfg_taps_m1 = '0;
    logic [1:0]                   cfg_other_taps_m1 = '0;
    logic [IDX_W-1:0]             cfg_width = 12'd16;
    logic                         cfg_edge_replicate = 1'b1;
    logic                         line_start = 1'b0;
    logic                         pix_strobe = 1'b0;
    logic                         out_valid;
    logic [5:0]                   out_phase;
    logic [2:0]                   out_step;
    logic                         out_bypass;
    logic [NT-1:0]                out_tap_en;
    logic [NT-1:0]                out_tap_black;
    logic [NT-1:0][IDX_W-1:0]     out_tap_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state
    longint m_pos;
    longint m_ratio;
    int     m_ntaps;
    bit     m_bypass;
    int     m_count;

    always #5 clk = ~clk;

    scl_phase_gen #(.IDX_W(IDX_W), .MAX_TAPS(NT)) uut (
        .clk(clk), .rst(rst),
        .cfg_ratio(cfg_ratio), .cfg_init_frac(cfg_init_frac),
        .cfg_taps_m1(cfg_taps_m1), .cfg_other_taps_m1(cfg_other_taps_m1),
        .cfg_width(cfg_width), .cfg_edge_replicate(cfg_edge_replicate),
        .line_start(line_start), .pix_strobe(pix_strobe),
        .out_valid(out_valid), .out_phase(out_phase), .out_step(out_step),
        .out_bypass(out_bypass), .out_tap_en(out_tap_en),
        .out_tap_black(out_tap_black), .out_tap_idx(out_tap_idx)
    );

    function automatic int field_taps(input logic [1:0] f);
        return (f == 2'd0) ? 1 : (f == 2'd1) ? 2 : 4;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // R2 R10: reference loads line config at start of line
    task automatic ref_load();
        m_ntaps  = field_taps(cfg_taps_m1);
        m_bypass = (field_taps(cfg_taps_m1) + field_taps(cfg_other_taps_m1)) <= 2;
        m_ratio  = m_bypass ? (longint'(1) << 24) : (longint'(cfg_ratio) << 5);
        m_pos    = (longint'(1) << 24) | (m_bypass ? 0 : longint'(cfg_init_frac));
        m_count  = 0;
    endtask

    task automatic start_line();
        @(negedge clk);
        line_start = 1'b1;
        ref_load();
        @(negedge clk);
        line_start = 1'b0;
        check(out_valid == 1'b0, "R6", "valid after line start", out_valid, 0);
    endtask

    task automatic compare_out();
        int     b, n, w, t, idx;
        bit     en, oob, blk;
        longint ph, st;
        n  = m_ntaps;
        w  = int'(cfg_width);
        b  = int'(m_pos >> 24) - 1;
        ph = (m_pos >> 18) & 63;
        st = ((m_pos + m_ratio) >> 24) - (m_pos >> 24);
        check(out_valid == 1'b1, "R6", "valid after strobe", out_valid, 1);
        check(out_phase == ph[5:0], "R4", "phase", out_phase, ph);
        check(out_step == st[2:0], "R5", "step", out_step, st);
        check(out_bypass == m_bypass, "R10", "bypass flag", out_bypass, m_bypass);
        if (m_bypass)
            check(int'(out_tap_idx[0]) == ((m_count < w) ? m_count : w - 1),
                  "R10", "bypass index", out_tap_idx[0], m_count);
        for (int k = 0; k < NT; k++) begin
            t   = b - (n - 1) / 2 + k;
            en  = (k < n);
            oob = (t < 0) || (t >= w);
            idx = !en ? 0 : (t < 0) ? 0 : (t >= w) ? w - 1 : t;
            blk = en && oob && !cfg_edge_replicate;
            check(out_tap_en[k] == en, "R7", "tap enable", out_tap_en[k], en);
            check(int'(out_tap_idx[k]) == idx, cfg_edge_replicate ? "R8" : "R9",
                  "tap index", out_tap_idx[k], idx);
            check(out_tap_black[k] == blk, "R9", "black flag", out_tap_black[k], blk);
        end
        m_pos   = m_pos + m_ratio; // R3
        m_count = m_count + 1;
    endtask

    task automatic strobe(input bit check_idle);
        @(negedge clk);
        pix_strobe = 1'b1;
        @(negedge clk);
        pix_strobe = 1'b0;
        compare_out();
        if (check_idle) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R6", "valid drops", out_valid, 0);
        end
    endtask

    function automatic logic [1:0] rand_taps();
        int r;
        r = int'($urandom_range(0, 2));
        return (r == 0) ? 2'd0 : (r == 1) ? 2'd1 : 2'd3;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
        check(out_phase == 6'd0, "R1", "phase after reset", out_phase, 0);
        check(out_step == 3'd0, "R1", "step after reset", out_step, 0);
        check(out_tap_en == '0, "R1", "tap enables after reset", out_tap_en, 0);

        // R3 R4: unity ratio, 4 taps, edges near viewport bounds (R8)
        cfg_ratio = 21'(1) << 19; cfg_init_frac = 24'h400000;
        cfg_taps_m1 = 2'd3; cfg_other_taps_m1 = 2'd3;
        cfg_width = 12'd3; cfg_edge_replicate = 1'b1;
        start_line();
        for (int i = 0; i < 5; i++) strobe(1'b1);

        // R9: same line shape in black mode
        cfg_edge_replicate = 1'b0;
        start_line();
        for (int i = 0; i < 5; i++) strobe(1'b0);

        // R2: config changes mid-line are ignored
        cfg_ratio = 21'h0C0000; cfg_init_frac = 24'hFC0000;
        cfg_taps_m1 = 2'd1; cfg_other_taps_m1 = 2'd0; cfg_width = 12'd20;
        start_line();
        strobe(1'b0); strobe(1'b0);
        cfg_ratio = 21'h010000; cfg_init_frac = 24'h000001;
        cfg_taps_m1 = 2'd3; cfg_other_taps_m1 = 2'd3;
        for (int i = 0; i < 4; i++) strobe(1'b0);

        // R6: line start and strobe together, start wins
        @(negedge clk);
        line_start = 1'b1; pix_strobe = 1'b1;
        ref_load();
        @(negedge clk);
        line_start = 1'b0; pix_strobe = 1'b0;
        check(out_valid == 1'b0, "R6", "start beats strobe", out_valid, 0);
        strobe(1'b1); strobe(1'b0);

        // R5: largest ratio gives step 4 after fractional carry
        cfg_ratio = 21'h1FFFFF; cfg_init_frac = 24'hFFFFFF; cfg_taps_m1 = 2'd1;
        cfg_width = 12'd40;
        start_line();
        for (int i = 0; i < 6; i++) strobe(1'b0);

        // R10: bypass ignores ratio and init
        cfg_ratio = 21'h123456; cfg_init_frac = 24'hABCDEF;
        cfg_taps_m1 = 2'd0; cfg_other_taps_m1 = 2'd0; cfg_width = 12'd6;
        start_line();
        for (int i = 0; i < 8; i++) strobe(1'b1);

        // random lines
        for (int ln = 0; ln < 40; ln++) begin
            cfg_ratio          = 21'($urandom);
            cfg_init_frac      = 24'($urandom);
            cfg_taps_m1        = rand_taps();
            cfg_other_taps_m1  = rand_taps();
            cfg_width          = 12'($urandom_range(1, 48));
            cfg_edge_replicate = 1'($urandom_range(0, 1));
            start_line();
            for (int p = 0; p < int'($urandom_range(1, 30)); p++) begin
                strobe(1'($urandom_range(0, 1)));
                if ($urandom_range(0, 3) == 0) cfg_ratio = 21'($urandom); // R2
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule